// File: doc/BRIEF.md
# DMA Channel Enable and Request Control

This block is the control logic of one channel of a simple DMA controller. It holds four control bits: the channel enable, the transfer-end interrupt enable, the source-clear enable and the repeat-mode select. It also holds a transfer counter. An activation request comes from a selected internal interrupt source. When the channel is enabled, the request starts one transfer and can also send a clear pulse back to the source. When the channel is disabled, the request is passed to the CPU as an ordinary interrupt.

The channel is armed in two steps. Software must first read the control register while the enable reads 0, and only then write 1 to the enable. In normal mode the enable drops by itself when the programmed count runs out. In repeat mode the counter reloads and the channel stays enabled. A transfer-end interrupt is raised whenever its enable is set while the channel is off.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the control register (address 0; bit 0 enable, bit 1 end-interrupt enable, bit 2 source-clear enable, bit 3 repeat) reads 0, and xfer_start, src_clear, cpu_irq and end_irq are all low.
- R2: While the enable is 0, a one-cycle act_req produces a one-cycle cpu_irq in the next cycle, and xfer_start stays low.
- R3: While the enable is 1, a one-cycle act_req produces exactly one one-cycle xfer_start in the next cycle, and cpu_irq stays low.
- R4: A write with bit 0 = 1 sets the enable only if the last access to the control register was a read that returned enable = 0. Any write to the control register consumes that qualification, so a later write of 1 without a fresh read leaves the enable at 0.
- R5: Writing bit 0 = 0 clears the enable from the next cycle on, and later requests are routed to the CPU.
- R6: The counter (address 1) is loaded by a write and reads back its current value. In normal mode (bit 3 = 0), each transfer decrements it, and the transfer that takes it from 1 to 0 clears the enable. A loaded count of 0 means 2^CNT_W transfers.
- R7: In repeat mode (bit 3 = 1), the transfer that would take the counter from 1 to 0 instead reloads the last written count, and the enable stays 1.
- R8: src_clear pulses in the same cycle as xfer_start when bit 2 is 1, and never pulses when bit 2 is 0.
- R9: end_irq is high exactly while the end-interrupt enable is 1 and the channel enable is 0. It rises the cycle after that condition is written, and it falls when software clears the interrupt enable or enables the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 control, 1 counter |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| act_req | input | 1 | Activation request pulse from the interrupt source |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| src_clear | output | 1 | One-cycle clear pulse to the interrupt source |
| cpu_irq | output | 1 | Request forwarded to the CPU while disabled |
| end_irq | output | 1 | Transfer-end interrupt request level |

## Verification
The assertions check on every cycle how each request is routed: to the CPU while disabled, to a transfer while enabled. They also check that a clear pulse only ever comes with a transfer, that an unqualified write of 1 leaves a disabled channel off, that the terminal transfer in normal mode drops the enable, and that the end interrupt only rises while disabled. The bench scenarios show the rest. These are the full arming sequence with its read-then-write order, the count values decrementing and reloading in both modes, and an abort followed by forwarded requests. They also cover the end interrupt being raised and cleared through register writes, and the state after a reset in mid-operation.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int unsigned CTRL_BITS = 4;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_ACK   = 2;
  localparam int unsigned BIT_RPT   = 3;
  localparam logic        ADDR_CTRL = 1'b0;
  localparam logic        ADDR_CNT  = 1'b1;
endpackage

// File: rtl/dma_cc_ctrl.sv
module dma_cc_ctrl
  import dma_cc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic                 rd_ctrl,
  input  logic [CTRL_BITS-1:0] wdata,
  input  logic                 term,
  output logic                 en,
  output logic                 ie,
  output logic                 ack_en,
  output logic                 rpt,
  output logic                 armed
);
  logic en_nxt, ie_nxt, ack_nxt, rpt_nxt, armed_nxt;

  always_comb begin
    en_nxt    = en;
    ie_nxt    = ie;
    ack_nxt   = ack_en;
    rpt_nxt   = rpt;
    armed_nxt = armed;
    if (wr_ctrl) begin
      en_nxt    = wdata[BIT_EN] ? (en | armed) : 1'b0;
      ie_nxt    = wdata[BIT_IE];
      ack_nxt   = wdata[BIT_ACK];
      rpt_nxt   = wdata[BIT_RPT];
      armed_nxt = 1'b0;
    end else begin
      if (term)
        en_nxt = 1'b0;
      if (rd_ctrl)
        armed_nxt = ~en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      ie     <= 1'b0;
      ack_en <= 1'b0;
      rpt    <= 1'b0;
      armed  <= 1'b0;
    end else begin
      en     <= en_nxt;
      ie     <= ie_nxt;
      ack_en <= ack_nxt;
      rpt    <= rpt_nxt;
      armed  <= armed_nxt;
    end
  end
endmodule

// File: rtl/dma_cc_count.sv
module dma_cc_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  input  logic             accept,
  input  logic             rpt,
  output logic [CNT_W-1:0] cnt,
  output logic             term
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nxt, reload, reload_nxt;
  logic             last;

  assign last = (cnt == ONE);
  assign term = accept & last & ~rpt;

  always_comb begin
    cnt_nxt    = cnt;
    reload_nxt = reload;
    if (wr_cnt) begin
      cnt_nxt    = wdata;
      reload_nxt = wdata;
    end else if (accept) begin
      if (last && rpt)
        cnt_nxt = reload;
      else
        cnt_nxt = cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
    end else begin
      cnt    <= cnt_nxt;
      reload <= reload_nxt;
    end
  end
endmodule

// File: rtl/dma_cc_route.sv
module dma_cc_route (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack_en,
  input  logic act_req,
  output logic accept,
  output logic xfer_start,
  output logic src_clear,
  output logic cpu_irq
);
  logic start_nxt, clr_nxt, cpu_nxt;

  always_comb begin
    accept    = en & act_req;
    start_nxt = accept;
    clr_nxt   = accept & ack_en;
    cpu_nxt   = act_req & ~en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_start <= 1'b0;
      src_clear  <= 1'b0;
      cpu_irq    <= 1'b0;
    end else begin
      xfer_start <= start_nxt;
      src_clear  <= clr_nxt;
      cpu_irq    <= cpu_nxt;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              act_req,
  output logic              xfer_start,
  output logic              src_clear,
  output logic              cpu_irq,
  output logic              end_irq
);
  logic rst_meta_n, rst_sync_n;
  logic wr_ctrl, rd_ctrl, wr_cnt;
  logic en, ie, ack_en, rpt, armed;
  logic accept, term;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wr_ctrl = reg_wr & (reg_addr == ADDR_CTRL);
  assign rd_ctrl = reg_rd & ~reg_wr & (reg_addr == ADDR_CTRL);
  assign wr_cnt  = reg_wr & (reg_addr == ADDR_CNT);

  dma_cc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ctrl (wr_ctrl),
    .rd_ctrl (rd_ctrl),
    .wdata   (reg_wdata[CTRL_BITS-1:0]),
    .term    (term),
    .en      (en),
    .ie      (ie),
    .ack_en  (ack_en),
    .rpt     (rpt),
    .armed   (armed)
  );

  dma_cc_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_cnt (wr_cnt),
    .wdata  (reg_wdata[CNT_W-1:0]),
    .accept (accept),
    .rpt    (rpt),
    .cnt    (cnt),
    .term   (term)
  );

  dma_cc_route u_route (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (en),
    .ack_en     (ack_en),
    .act_req    (act_req),
    .accept     (accept),
    .xfer_start (xfer_start),
    .src_clear  (src_clear),
    .cpu_irq    (cpu_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[BIT_EN]  = en;
      reg_rdata[BIT_IE]  = ie;
      reg_rdata[BIT_ACK] = ack_en;
      reg_rdata[BIT_RPT] = rpt;
    end else begin
      reg_rdata[CNT_W-1:0] = cnt;
    end
  end

  assign end_irq = ie & ~en;
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              armed,
  input logic              rpt,
  input logic              wr_ctrl,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              act_req,
  input logic              xfer_start,
  input logic              src_clear,
  input logic              cpu_irq,
  input logic              end_irq
);
  // R2
  a_r2_disabled_to_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && act_req) |=> (cpu_irq && !xfer_start));
  // R3
  a_r3_enabled_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_req) |=> (xfer_start && !cpu_irq));
  // R4
  a_r4_unarmed_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[0] && !armed && !en) |=> !en);
  // R6
  a_r6_terminal_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_req && !rpt && !wr_ctrl && cnt == CNT_W'(1)) |=> !en);
  // R8
  a_r8_clear_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    src_clear |-> xfer_start);
  // R9
  a_r9_end_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_irq) |-> !en);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .en         (en),
  .armed      (armed),
  .rpt        (rpt),
  .wr_ctrl    (wr_ctrl),
  .reg_wdata  (reg_wdata),
  .cnt        (cnt),
  .act_req    (act_req),
  .xfer_start (xfer_start),
  .src_clear  (src_clear),
  .cpu_irq    (cpu_irq),
  .end_irq    (end_irq)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  // vector: op[1:0] (0 write, 1 read, 2 request), addr, data, expect
  // request expect bits: [0] xfer_start, [1] src_clear, [2] cpu_irq
  localparam int NV = 21;
  localparam logic [18:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'h00, 8'h00},  // R1 reset read, arms
    {2'd0, 1'b1, 8'h03, 8'h00},
    {2'd1, 1'b1, 8'h00, 8'h03},  // R6 count readback
    {2'd0, 1'b0, 8'h01, 8'h00},  // R4 armed write sets enable
    {2'd1, 1'b0, 8'h00, 8'h01},  // R4
    {2'd2, 1'b0, 8'h00, 8'h01},  // R3
    {2'd1, 1'b1, 8'h00, 8'h02},  // R6 decrement
    {2'd2, 1'b0, 8'h00, 8'h01},  // R3 R8 no clear
    {2'd2, 1'b0, 8'h00, 8'h01},  // R6 terminal
    {2'd1, 1'b0, 8'h00, 8'h00},  // R6 enable cleared
    {2'd1, 1'b1, 8'h00, 8'h00},  // R6
    {2'd2, 1'b0, 8'h00, 8'h04},  // R2
    {2'd0, 1'b0, 8'h0D, 8'h00},
    {2'd0, 1'b1, 8'h02, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'h03},  // R8 clear pulse
    {2'd2, 1'b0, 8'h00, 8'h03},  // R7 reload
    {2'd1, 1'b1, 8'h00, 8'h02},  // R7
    {2'd1, 1'b0, 8'h00, 8'h0D},  // R7 still enabled
    {2'd0, 1'b0, 8'h00, 8'h00},  // R5 abort
    {2'd1, 1'b0, 8'h00, 8'h00},  // R5
    {2'd2, 1'b0, 8'h00, 8'h04}   // R5 routed to cpu
  };

  logic clk, rst_n, reg_addr, reg_wr, reg_rd, act_req;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic xfer_start, src_clear, cpu_irq, end_irq;
  int tests, fails;

  dma_chan_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .act_req(act_req), .xfer_start(xfer_start), .src_clear(src_clear),
    .cpu_irq(cpu_irq), .end_irq(end_irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic a, input logic [7:0] exp, input string req);
    reg_addr = a; reg_rd = 1'b1;
    #1 check(req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_req(input logic [7:0] exp, input string req);
    act_req = 1'b1;
    @(negedge clk);
    act_req = 1'b0;
    #1 check(req, {5'd0, cpu_irq, src_clear, xfer_start}, exp);
    @(negedge clk);
    check(req, {5'd0, cpu_irq, src_clear, xfer_start}, 8'h00);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0;
    reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = '0; act_req = 0;
    @(negedge clk);
    do_reset();
    check("R1 outputs", {4'd0, xfer_start, src_clear, cpu_irq, end_irq}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][18:17])
        2'd0: do_wr(VEC[i][16], VEC[i][15:8]);
        2'd1: do_rd(VEC[i][16], VEC[i][7:0], $sformatf("vec%0d R1-R7", i));
        default: do_req(VEC[i][7:0], $sformatf("vec%0d R2/R3/R8", i));
      endcase
    end
    // R9 end interrupt raised while disabled; R4 flag consumed by that write
    do_rd(1'b0, 8'h00, "R5 disabled");
    do_wr(1'b0, 8'h02);
    check("R9 raise", {7'd0, end_irq}, 8'h01);
    do_wr(1'b0, 8'h03);
    do_rd(1'b0, 8'h02, "R4 unarmed write ignored");
    check("R9 held", {7'd0, end_irq}, 8'h01);
    do_wr(1'b0, 8'h03);
    do_rd(1'b0, 8'h03, "R4 armed after read");
    check("R9 cleared by enable", {7'd0, end_irq}, 8'h00);
    do_wr(1'b0, 8'h02);
    check("R9 abort raises", {7'd0, end_irq}, 8'h01);
    do_wr(1'b0, 8'h00);
    check("R9 cleared by ie", {7'd0, end_irq}, 8'h00);
    // mid-operation reset
    do_rd(1'b0, 8'h00, "R5");
    do_wr(1'b0, 8'h0F);
    do_reset();
    do_rd(1'b0, 8'h00, "R1 reset control");
    check("R1 end_irq", {7'd0, end_irq}, 8'h00);
    do_req(8'h04, "R2 after reset");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule